// File: doc/BRIEF.md
# Dual-Issue Pair Hazard Checker

This block is the issue-stage gate of a two-wide in-order pipeline. Every cycle it looks at one aligned fetch packet of two decoded instructions. The first position holds an integer-side operation: an ALU op, a load, a store or a branch. The second position holds a floating-point arithmetic op. The block then decides whether both positions issue, only the first issues, or nothing issues. It raises a stall whenever a present instruction is held back. The fetch side then presents the held part again, with a held second instruction moving into the first position.

Three hazard sources are checked. The first is the pair format: a packet that breaks the integer-first / FP-second layout issues at most its first instruction. Because the second position may only carry an FP arithmetic op, no cycle can issue two memory operations or two branches. The second is a same-packet read-after-write: a load in the first position feeds a source of the second. The third is the load-use shadow: a small scoreboard records the destination of every issued load, and any source that matches a recorded destination is blocked for the following `LOAD_SHADOW` cycles. FP loads and stores reach the FP register file through their own port, so they never conflict with the FP op beside them.

Register operands are tags of `REG_W+1` bits. The top bit selects the file: 1 is FP and 0 is integer. The lower `REG_W` bits are the index.

Top module: `dig_issue_gate`

## Requirements
- R1: While `rst_n` is low, `issue0`, `issue1` and `stall` are 0, and the load scoreboard is emptied, so no shadow survives reset.
- R2: With `pkt_vld` low, nothing issues and `stall` is 0. With `s1_vld` low, the second-position fields have no effect: the first instruction issues or holds on its own, and `stall` depends only on it.
- R3: A packet with a legal pair and no hazard issues both positions in the same cycle with `stall` 0. This includes an FP load or FP store in the first position beside an FP op that reads the same FP register as the store data.
- R4: Class codes are 0 int ALU, 1 int load, 2 int store, 3 FP load, 4 FP store, 5 branch, 6 FP ALU and 7 reserved. The first position is legal for codes 0 to 5 and the second for code 6 only. Any other pairing issues at most the first instruction and raises `stall`.
- R5: If the first position is a load (code 1 or 3) with write enable, and its destination tag equals an enabled source of the second position, the second is held while the first issues, and `stall` is 1.
- R6: A load issued in cycle t blocks any instruction with an enabled source equal to its destination during cycles t+1 to t+`LOAD_SHADOW` (default 1). The same instruction issues in the cycle after that.
- R7: If the first instruction is held, the second is held too (`issue1` implies `issue0`) and `stall` is 1.
- R8: A second instruction whose source lies in a load shadow is held alone: the first issues and `stall` is 1.
- R9: Tags match only when all `REG_W+1` bits are equal, including the file bit. A source whose enable is 0 never matches.
- R10: A load that is held creates no shadow. Only issued loads enter the scoreboard.
- R11: Non-load instructions (ALU, store, branch) create no shadow, even when their write enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_vld | input | 1 | First position holds an instruction |
| s0_cls | input | 3 | First-position class code |
| s0_rd_a_en | input | 1 | First-position source A used |
| s0_rd_a | input | REG_W+1 | First-position source A tag |
| s0_rd_b_en | input | 1 | First-position source B used |
| s0_rd_b | input | REG_W+1 | First-position source B tag |
| s0_wr_en | input | 1 | First-position writes a register |
| s0_wr | input | REG_W+1 | First-position destination tag |
| s1_vld | input | 1 | Second position holds an instruction |
| s1_cls | input | 3 | Second-position class code |
| s1_rd_a_en | input | 1 | Second-position source A used |
| s1_rd_a | input | REG_W+1 | Second-position source A tag |
| s1_rd_b_en | input | 1 | Second-position source B used |
| s1_rd_b | input | REG_W+1 | Second-position source B tag |
| issue0 | output | 1 | First position issues this cycle |
| issue1 | output | 1 | Second position issues this cycle |
| stall | output | 1 | A present instruction was held |

## Verification
The issue and stall outputs are combinational in the presented packet and the scoreboard, so they are due in the same cycle the packet is driven. The bench therefore drives each packet just after a falling edge and samples the outputs 2 ns later, before the next rising edge. A load's shadow takes effect only from the cycle after the rising edge at which the load issued, and it lasts `LOAD_SHADOW` cycles. The reference model ages its list of pending loads exactly once per cycle, after it has compared that cycle's outputs, so every shadow check lands in the cycle it is due and not one cycle early or late.

// File: rtl/dig_pkg.sv
package dig_pkg;

   typedef enum logic [2:0] {
      CLS_INT_ALU   = 3'd0,
      CLS_INT_LOAD  = 3'd1,
      CLS_INT_STORE = 3'd2,
      CLS_FP_LOAD   = 3'd3,
      CLS_FP_STORE  = 3'd4,
      CLS_BRANCH    = 3'd5,
      CLS_FP_ALU    = 3'd6,
      CLS_RSVD      = 3'd7
   } op_class_e;

   // integer-side classes may occupy the first position of a pair
   function automatic logic cls_int_side(input logic [2:0] c);
      return (c <= 3'd5);
   endfunction

   function automatic logic cls_is_load(input logic [2:0] c);
      return (c == CLS_INT_LOAD) || (c == CLS_FP_LOAD);
   endfunction

   function automatic logic cls_fp_exec(input logic [2:0] c);
      return (c == CLS_FP_ALU);
   endfunction

endpackage

// File: rtl/dig_load_shadow.sv
module dig_load_shadow #(
   parameter int TAG_W = 6,
   parameter int DEPTH = 1,
   parameter int N_Q   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_en,
   input  logic [TAG_W-1:0] push_tag,
   input  logic [N_Q-1:0]   q_en,
   input  logic [TAG_W-1:0] q_tag [N_Q],
   output logic [N_Q-1:0]   q_hit
);

   initial begin
      AST_SHADOW_DEPTH_RANGE: assert (DEPTH >= 1 && DEPTH <= 8)
         else $error("DEPTH must lie in 1..8");
      AST_QUERY_COUNT: assert (N_Q >= 1)
         else $error("N_Q must be at least 1");
   end

   // stage k holds the load that issued k+1 cycles ago
   logic             stg_vld [DEPTH];
   logic [TAG_W-1:0] stg_tag [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_vld[0] <= 1'b0;
         stg_tag[0] <= '0;
      end else begin
         stg_vld[0] <= push_en;
         stg_tag[0] <= push_tag;
      end
   end

   for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_vld[k] <= 1'b0;
            stg_tag[k] <= '0;
         end else begin
            stg_vld[k] <= stg_vld[k-1];
            stg_tag[k] <= stg_tag[k-1];
         end
      end
   end

   for (genvar q = 0; q < N_Q; q++) begin : g_query
      logic hit_q;
      always_comb begin
         hit_q = 1'b0;
         for (int k = 0; k < DEPTH; k++) begin
            if (stg_vld[k] && (stg_tag[k] == q_tag[q])) hit_q = 1'b1;
         end
      end
      assign q_hit[q] = hit_q & q_en[q];

      AST_SHADOW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(push_en && rst_n) && q_en[q] && (q_tag[q] == $past(push_tag))) |-> q_hit[q]) // R6
         else $error("source in fresh load shadow not flagged");

      AST_DISABLED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         !q_en[q] |-> !q_hit[q]) // R9
         else $error("disabled source reported a hit");
   end

endmodule

// File: rtl/dig_pair_rules.sv
module dig_pair_rules
   import dig_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic [2:0]       s0_cls,
   input  logic             s0_wr_en,
   input  logic [TAG_W-1:0] s0_wr,
   input  logic [2:0]       s1_cls,
   input  logic             s1_rd_a_en,
   input  logic [TAG_W-1:0] s1_rd_a,
   input  logic             s1_rd_b_en,
   input  logic [TAG_W-1:0] s1_rd_b,
   output logic             pair_ok,
   output logic             same_raw
);

   logic s0_feeds;

   assign pair_ok  = cls_int_side(s0_cls) & cls_fp_exec(s1_cls);
   assign s0_feeds = cls_is_load(s0_cls) & s0_wr_en;
   assign same_raw = s0_feeds &
                     ((s1_rd_a_en & (s1_rd_a == s0_wr)) |
                      (s1_rd_b_en & (s1_rd_b == s0_wr)));

endmodule

// File: rtl/dig_issue_gate.sv
module dig_issue_gate
   import dig_pkg::*;
#(
   parameter  int REG_W       = 5,
   parameter  int LOAD_SHADOW = 1,
   localparam int TAG_W       = REG_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_vld,
   input  logic [2:0]       s0_cls,
   input  logic             s0_rd_a_en,
   input  logic [TAG_W-1:0] s0_rd_a,
   input  logic             s0_rd_b_en,
   input  logic [TAG_W-1:0] s0_rd_b,
   input  logic             s0_wr_en,
   input  logic [TAG_W-1:0] s0_wr,
   input  logic             s1_vld,
   input  logic [2:0]       s1_cls,
   input  logic             s1_rd_a_en,
   input  logic [TAG_W-1:0] s1_rd_a,
   input  logic             s1_rd_b_en,
   input  logic [TAG_W-1:0] s1_rd_b,
   output logic             issue0,
   output logic             issue1,
   output logic             stall
);

   localparam int N_SRC = 4;

   initial begin
      AST_REG_W_RANGE: assert (REG_W >= 1 && REG_W <= 8)
         else $error("REG_W must lie in 1..8");
   end

   logic [N_SRC-1:0] src_en;
   logic [TAG_W-1:0] src_tag [N_SRC];
   logic [N_SRC-1:0] src_hit;
   logic             pair_ok;
   logic             same_raw;
   logic             hold0;
   logic             hold1;
   logic             go0;
   logic             go1;
   logic             push_en;

   assign src_en     = {s1_rd_b_en, s1_rd_a_en, s0_rd_b_en, s0_rd_a_en};
   assign src_tag[0] = s0_rd_a;
   assign src_tag[1] = s0_rd_b;
   assign src_tag[2] = s1_rd_a;
   assign src_tag[3] = s1_rd_b;

   dig_load_shadow #(
      .TAG_W (TAG_W),
      .DEPTH (LOAD_SHADOW),
      .N_Q   (N_SRC)
   ) i_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (push_en),
      .push_tag (s0_wr),
      .q_en     (src_en),
      .q_tag    (src_tag),
      .q_hit    (src_hit)
   );

   dig_pair_rules #(
      .TAG_W (TAG_W)
   ) i_rules (
      .s0_cls     (s0_cls),
      .s0_wr_en   (s0_wr_en),
      .s0_wr      (s0_wr),
      .s1_cls     (s1_cls),
      .s1_rd_a_en (s1_rd_a_en),
      .s1_rd_a    (s1_rd_a),
      .s1_rd_b_en (s1_rd_b_en),
      .s1_rd_b    (s1_rd_b),
      .pair_ok    (pair_ok),
      .same_raw   (same_raw)
   );

   assign hold0   = |src_hit[1:0];
   assign hold1   = (|src_hit[3:2]) | same_raw | ~pair_ok;
   assign go0     = rst_n & pkt_vld & ~hold0;
   assign go1     = go0 & s1_vld & ~hold1;
   assign push_en = go0 & cls_is_load(s0_cls) & s0_wr_en;

   assign issue0 = go0;
   assign issue1 = go1;
   assign stall  = rst_n & pkt_vld & (~go0 | (s1_vld & ~go1));

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!issue0 && !issue1 && !stall)) // R1
      else $error("activity during reset");

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_vld |-> (!issue0 && !issue1 && !stall)) // R2
      else $error("activity with no packet");

   AST_FULL_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (issue0 && (issue1 || !s1_vld)) |-> !stall) // R3
      else $error("stall with every instruction issued");

   AST_PAIR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_vld && s1_vld && (!cls_int_side(s0_cls) || (s1_cls != CLS_FP_ALU))) |-> !issue1) // R4
      else $error("illegal pair issued both positions");

   AST_SAME_PKT_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_vld && s1_vld && cls_is_load(s0_cls) && s0_wr_en &&
       s1_rd_a_en && (s1_rd_a == s0_wr)) |-> !issue1) // R5
      else $error("second position read a same-packet load result");

   AST_ISSUE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      issue1 |-> (issue0 && s1_vld)) // R7
      else $error("second position issued ahead of the first");

   AST_HOLD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_vld && !issue0) |-> stall) // R7
      else $error("held first position without stall");

endmodule

// File: tb/test_dig_issue_gate.sv
module test_dig_issue_gate;

   localparam int REG_W  = 5;
   localparam int TAG_W  = REG_W + 1;
   localparam int SHADOW = 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pkt_vld = 1'b0;
   logic [2:0]       s0_cls = '0;
   logic             s0_rd_a_en = 1'b0;
   logic [TAG_W-1:0] s0_rd_a = '0;
   logic             s0_rd_b_en = 1'b0;
   logic [TAG_W-1:0] s0_rd_b = '0;
   logic             s0_wr_en = 1'b0;
   logic [TAG_W-1:0] s0_wr = '0;
   logic             s1_vld = 1'b0;
   logic [2:0]       s1_cls = '0;
   logic             s1_rd_a_en = 1'b0;
   logic [TAG_W-1:0] s1_rd_a = '0;
   logic             s1_rd_b_en = 1'b0;
   logic [TAG_W-1:0] s1_rd_b = '0;
   logic             issue0;
   logic             issue1;
   logic             stall;

   int n_chk  = 0;
   int n_fail = 0;
   int sb_tag  [$];
   int sb_left [$];

   always #4 clk = ~clk;   // 125 MHz

   dig_issue_gate #(.REG_W(REG_W), .LOAD_SHADOW(SHADOW)) i_dig_issue_gate (
      .clk(clk), .rst_n(rst_n), .pkt_vld(pkt_vld),
      .s0_cls(s0_cls), .s0_rd_a_en(s0_rd_a_en), .s0_rd_a(s0_rd_a),
      .s0_rd_b_en(s0_rd_b_en), .s0_rd_b(s0_rd_b),
      .s0_wr_en(s0_wr_en), .s0_wr(s0_wr),
      .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_rd_a_en(s1_rd_a_en), .s1_rd_a(s1_rd_a),
      .s1_rd_b_en(s1_rd_b_en), .s1_rd_b(s1_rd_b),
      .issue0(issue0), .issue1(issue1), .stall(stall)
   );

   function automatic logic [TAG_W-1:0] ir(input int n);
      return TAG_W'(n);
   endfunction

   function automatic logic [TAG_W-1:0] fr(input int n);
      return TAG_W'((1 << REG_W) + n);
   endfunction

   function automatic bit in_shadow(input bit en, input int t);
      if (!en) return 1'b0;
      foreach (sb_tag[i]) if (sb_tag[i] == t && sb_left[i] > 0) return 1'b1;
      return 1'b0;
   endfunction

   task automatic slot0(input int cls, input bit ae, input logic [TAG_W-1:0] a,
                        input bit be, input logic [TAG_W-1:0] b,
                        input bit we, input logic [TAG_W-1:0] w);
      pkt_vld = 1'b1; s0_cls = 3'(cls);
      s0_rd_a_en = ae; s0_rd_a = a; s0_rd_b_en = be; s0_rd_b = b;
      s0_wr_en = we; s0_wr = w;
   endtask

   task automatic slot1(input bit v, input int cls, input bit ae, input logic [TAG_W-1:0] a,
                        input bit be, input logic [TAG_W-1:0] b);
      s1_vld = v; s1_cls = 3'(cls);
      s1_rd_a_en = ae; s1_rd_a = a; s1_rd_b_en = be; s1_rd_b = b;
   endtask

   task automatic check(input string req, input string name, input bit act, input bit exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, name, act, exp);
      end
   endtask

   // called just after a falling edge with inputs applied
   task automatic step(input string req);
      bit e0, e1, es, ld, legal, hz0, hz1;
      #2;
      if (!rst_n) begin
         e0 = 0; e1 = 0; es = 0;
         sb_tag.delete(); sb_left.delete();
      end else begin
         ld    = (s0_cls == 3'd1 || s0_cls == 3'd3) && s0_wr_en;
         legal = (s0_cls <= 3'd5) && (s1_cls == 3'd6);
         hz0   = in_shadow(s0_rd_a_en, int'(s0_rd_a)) || in_shadow(s0_rd_b_en, int'(s0_rd_b));
         hz1   = in_shadow(s1_rd_a_en, int'(s1_rd_a)) || in_shadow(s1_rd_b_en, int'(s1_rd_b)) ||
                 (ld && ((s1_rd_a_en && s1_rd_a == s0_wr) || (s1_rd_b_en && s1_rd_b == s0_wr)));
         e0 = pkt_vld && !hz0;
         e1 = e0 && s1_vld && legal && !hz1;
         es = pkt_vld && (!e0 || (s1_vld && !e1));
      end
      check(req, "issue0", issue0, e0);
      check(req, "issue1", issue1, e1);
      check(req, "stall",  stall,  es);
      if (rst_n) begin
         foreach (sb_left[i]) sb_left[i]--;
         for (int i = sb_left.size() - 1; i >= 0; i--)
            if (sb_left[i] <= 0) begin sb_left.delete(i); sb_tag.delete(i); end
         if (e0 && (s0_cls == 3'd1 || s0_cls == 3'd3) && s0_wr_en) begin
            sb_tag.push_back(int'(s0_wr)); sb_left.push_back(SHADOW);
         end
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      // R1: packet presented during reset must not issue
      slot0(1, 1, ir(1), 0, ir(0), 1, ir(2)); slot1(1, 6, 1, fr(1), 1, fr(2));
      repeat (3) step("R1");
      rst_n = 1'b1;
      // R1: load under reset left no shadow: reader of r2 issues
      slot0(0, 1, ir(2), 0, ir(0), 1, ir(3)); slot1(0, 6, 0, fr(0), 0, fr(0));
      step("R1");
      // R2: no packet
      pkt_vld = 1'b0; step("R2");
      // R3: legal independent pair
      slot0(0, 1, ir(2), 1, ir(3), 1, ir(1)); slot1(1, 6, 1, fr(1), 1, fr(2));
      step("R3");
      // R2: second position absent, illegal class in its fields is ignored
      slot0(0, 1, ir(2), 1, ir(3), 1, ir(1)); slot1(0, 7, 1, fr(1), 1, fr(2));
      step("R2");
      // R5: FP load f3 feeds FP op in same packet
      slot0(3, 1, ir(1), 0, ir(0), 1, fr(3)); slot1(1, 6, 1, fr(3), 1, fr(4));
      step("R5");
      // R6: re-presented FP op now in shadow, then free
      slot0(6, 1, fr(3), 1, fr(4), 1, fr(5)); slot1(0, 6, 0, fr(0), 0, fr(0));
      step("R6");
      step("R6");
      // R4: FP op in first position with FP op second
      slot0(6, 1, fr(1), 0, fr(0), 1, fr(6)); slot1(1, 6, 1, fr(2), 0, fr(0));
      step("R4");
      // R4: two memory ops (int load r4, int store second)
      slot0(1, 1, ir(1), 0, ir(0), 1, ir(4)); slot1(1, 2, 1, ir(2), 0, ir(0));
      step("R4");
      // R7: first reads r4 in shadow, both held
      slot0(0, 1, ir(4), 0, ir(0), 1, ir(6)); slot1(1, 6, 1, fr(1), 0, fr(0));
      step("R7");
      step("R6");
      // R3: FP load f5 with independent FP op
      slot0(3, 1, ir(1), 0, ir(0), 1, fr(5)); slot1(1, 6, 1, fr(6), 1, fr(7));
      step("R3");
      // R8: second reads f5 in shadow
      slot0(0, 1, ir(1), 0, ir(0), 1, ir(8)); slot1(1, 6, 1, fr(1), 1, fr(5));
      step("R8");
      // R9: int load r5, then f5 reader is unaffected
      slot0(1, 1, ir(1), 0, ir(0), 1, ir(5)); slot1(1, 6, 1, fr(1), 0, fr(0));
      step("R3");
      slot0(4, 1, ir(2), 1, fr(9), 0, ir(0)); slot1(1, 6, 1, fr(5), 1, fr(9));
      step("R9");
      // R9: disabled source equal to a shadowed tag
      slot0(1, 1, ir(1), 0, ir(0), 1, ir(6)); slot1(0, 6, 0, fr(0), 0, fr(0));
      step("R3");
      slot0(0, 0, ir(6), 0, ir(6), 1, ir(7)); slot1(1, 6, 0, fr(0), 1, fr(1));
      step("R9");
      // R4: branch pair and reserved first class
      slot0(5, 1, ir(1), 0, ir(0), 0, ir(0)); slot1(1, 5, 1, ir(2), 0, ir(0));
      step("R4");
      slot0(7, 0, ir(0), 0, ir(0), 0, ir(0)); slot1(1, 6, 1, fr(1), 0, fr(0));
      step("R4");
      // R10: held load leaves no shadow
      slot0(1, 1, ir(1), 0, ir(0), 1, ir(2)); slot1(0, 6, 0, fr(0), 0, fr(0));
      step("R3");
      slot0(1, 1, ir(2), 0, ir(0), 1, ir(7)); step("R7");
      slot0(0, 1, ir(7), 0, ir(0), 1, ir(9)); step("R10");
      // R11: ALU write and branch then readers
      slot0(0, 1, ir(1), 0, ir(0), 1, ir(9)); slot1(1, 6, 1, fr(1), 0, fr(0));
      step("R11");
      slot0(5, 1, ir(9), 0, ir(0), 1, ir(10)); step("R11");
      slot0(2, 1, ir(10), 1, ir(9), 1, ir(11)); step("R11");
      slot0(0, 1, ir(11), 0, ir(0), 0, ir(0)); step("R11");
      // R3: FP store data and FP op read the same register
      slot0(4, 1, ir(1), 1, fr(2), 0, ir(0)); slot1(1, 6, 1, fr(2), 1, fr(3));
      step("R3");
      // random mix of all rules (R4 R5 R6 R7 R8 R9)
      for (int n = 0; n < 600; n++) begin
         int c0;
         c0 = ($urandom % 4 == 0) ? 3 : ($urandom % 8);
         slot0(c0, 1'($urandom), TAG_W'((($urandom % 2) << REG_W) | ($urandom % 4)),
               1'($urandom), TAG_W'((($urandom % 2) << REG_W) | ($urandom % 4)),
               ($urandom % 4 != 0), TAG_W'((($urandom % 2) << REG_W) | ($urandom % 4)));
         slot1(($urandom % 4 != 0), ($urandom % 4 == 0) ? ($urandom % 8) : 6,
               1'($urandom), TAG_W'((($urandom % 2) << REG_W) | ($urandom % 4)),
               1'($urandom), TAG_W'((($urandom % 2) << REG_W) | ($urandom % 4)));
         pkt_vld = ($urandom % 10 != 0);
         step("random R5 R6 R7 R8");
      end
      // R1: reset mid-run clears a fresh shadow
      slot0(1, 1, ir(1), 0, ir(0), 1, ir(12)); slot1(0, 6, 0, fr(0), 0, fr(0));
      step("R3");
      rst_n = 1'b0; step("R1");
      rst_n = 1'b1;
      slot0(0, 1, ir(12), 0, ir(0), 0, ir(0)); step("R1");
      finish_run();
   end

endmodule